// File: doc/BRIEF.md
# INCR Burst End Predictor

This block watches the AHB transfers that one master sends to one slave. Undefined-length incrementing bursts can otherwise hold a slave for hundreds of beats. To limit that, the block chops each such burst into virtual fixed-length bursts. It raises a one-cycle pulse on the beat that closes each virtual burst. The arbiter of that slave reads the pulse as a legal re-arbitration point, the same as the last beat of a fixed-length burst.

A 3-bit length code sets the virtual length:

| Code | Virtual length |
|------|----------------|
| 0 | Unlimited: the burst is never chopped |
| 1 | 1 beat |
| 2 to 7 | 2^code beats (4, 8, 16, 32, 64 or 128) |

The code is taken at the first beat of each burst. Bursts of other types pass by without effect. The pulse is combinational from the current transfer and registered state, so the arbiter sees it in the same cycle as the beat it marks.

Top module: `incr_burst_chopper`

## Requirements
- R1: Encodings are as follows. Transfer type: IDLE=2'b00, BUSY=2'b01, NONSEQ=2'b10, SEQ=2'b11. Burst type INCR=3'b001. A beat completes when the transfer type is NONSEQ or SEQ and ready is high. The pulse is only ever high during a completing beat of an INCR burst.
- R2: With code 0 (unlimited), no pulse is produced, however long the burst runs.
- R3: With code 1, every completing beat of an INCR burst produces a pulse, including its NONSEQ beat.
- R4: With code c from 2 to 7, the virtual length is N = 2^c. The pulse is high on completed beats N, 2N, 3N and so on of the burst. A burst whose length is not a multiple of N gives floor(length/N) pulses.
- R5: A NONSEQ beat on an INCR burst restarts the beat count, even when no IDLE separates it from the previous burst.
- R6: BUSY cycles neither advance the beat count nor produce a pulse.
- R7: Cycles with ready low neither advance the beat count nor produce a pulse.
- R8: An IDLE transfer ends tracking. SEQ beats that follow without a fresh NONSEQ produce no pulse.
- R9: When the burst type is not INCR, no pulse is produced, whatever the code.
- R10: The code is sampled on the NONSEQ beat. Changing it in the middle of a burst only affects the next burst.
- R11: While reset is asserted, the pulse is low. After reset, no burst is tracked and the stored length is unlimited.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| htrans_i | input | 2 | Transfer type of the current beat |
| hburst_i | input | 3 | Burst type of the current beat |
| hready_i | input | 1 | High when the current transfer completes |
| ulen_code_i | input | 3 | Virtual burst length code |
| vend_o | output | 1 | Predicted end-of-burst pulse |

## Verification
Each code from 0 to 7 is run on INCR bursts whose lengths are not multiples of the virtual length. These runs separate a correct wrap from counting one beat too early or too late. The same bursts are then repeated with BUSY cycles and wait states inserted, which exposes a counter that advances on beats that do not complete. Further runs start back-to-back NONSEQ bursts with no IDLE between them, send SEQ beats after an IDLE, use a fixed-length burst type, and change the code mid-burst. These tell a proper restart, a proper end of tracking and a properly latched code apart from logic that reads the live inputs.

// File: rtl/ulb_pkg.sv
package ulb_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  localparam logic [2:0] BURST_INCR = 3'b001;

endpackage

// File: rtl/ulb_rst_sync.sv
module ulb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_s = out_q;

endmodule

// File: rtl/ulb_len_decode.sv
// Maps the length code to an enable and a terminal count (length - 1).
module ulb_len_decode #(
  parameter int CFG_W = 3,
  parameter int CNT_W = 7
) (
  input  logic [CFG_W-1:0] code_i,
  output logic             en_o,
  output logic [CNT_W-1:0] term_o
);

  localparam int NCODE = 1 << CFG_W;

  logic [CNT_W-1:0] term_tbl [NCODE];

  // Code 0: unlimited, code 1: single beat, code c >= 2: 2^c beats.
  for (genvar g = 0; g < NCODE; g++) begin : g_tbl
    if (g < 2) begin : g_small
      assign term_tbl[g] = '0;
    end else if (g <= CNT_W) begin : g_pow
      assign term_tbl[g] = CNT_W'((1 << g) - 1);
    end else begin : g_sat
      assign term_tbl[g] = '1;
    end
  end

  assign term_o = term_tbl[code_i];
  assign en_o   = (code_i != '0);

endmodule

// File: rtl/ulb_xfer_class.sv
// Classifies the current transfer for the beat counter.
module ulb_xfer_class
  import ulb_pkg::*;
(
  input  logic [1:0] htrans_i,
  input  logic [2:0] hburst_i,
  input  logic       hready_i,
  input  logic       active_i,
  output logic       start_o,
  output logic       done_o,
  output logic       drop_o
);

  trans_e tr;
  logic   is_incr;
  logic   cont;

  always_comb begin
    tr      = trans_e'(htrans_i);
    is_incr = (hburst_i == BURST_INCR);
    start_o = is_incr && (tr == TR_NSEQ);
    cont    = is_incr && (tr == TR_SEQ) && active_i;
    done_o  = (start_o || cont) && hready_i;
    drop_o  = !is_incr || (tr == TR_IDLE);
  end

endmodule

// File: rtl/ulb_beat_ctr.sv
// Beat counter with latched virtual length and wrap at the terminal count.
module ulb_beat_ctr #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             drop_i,
  input  logic             code_en_i,
  input  logic [CNT_W-1:0] code_term_i,
  output logic             hit_o,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] term_o
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] term_q, term_n;
  logic             en_q, en_n;
  logic             act_q, act_n;
  logic             cnt_ce, len_ce, act_ce;

  logic             eff_en;
  logic [CNT_W-1:0] eff_term;
  logic [CNT_W-1:0] eff_cnt;
  logic             hit;

  always_comb begin
    eff_en   = start_i ? code_en_i   : en_q;
    eff_term = start_i ? code_term_i : term_q;
    eff_cnt  = start_i ? '0          : cnt_q;
    hit      = rst_n && done_i && eff_en && (eff_cnt == eff_term);
  end

  always_comb begin
    cnt_n  = cnt_q;
    term_n = term_q;
    en_n   = en_q;
    act_n  = act_q;
    cnt_ce = 1'b0;
    len_ce = 1'b0;
    act_ce = 1'b0;
    if (drop_i) begin
      cnt_n  = '0;
      act_n  = 1'b0;
      cnt_ce = 1'b1;
      act_ce = 1'b1;
    end else if (start_i) begin
      act_n  = 1'b1;
      en_n   = code_en_i;
      term_n = code_term_i;
      cnt_n  = (done_i && !hit && code_en_i) ? CNT_W'(1) : '0;
      cnt_ce = 1'b1;
      len_ce = 1'b1;
      act_ce = 1'b1;
    end else if (done_i) begin
      cnt_ce = 1'b1;
      if (hit || !en_q) begin
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q <= '0;
      en_q   <= 1'b0;
    end else if (len_ce) begin
      term_q <= term_n;
      en_q   <= en_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (act_ce) begin
      act_q <= act_n;
    end
  end

  assign hit_o    = hit;
  assign active_o = act_q;
  assign cnt_o    = cnt_q;
  assign term_o   = term_q;

endmodule

// File: rtl/incr_burst_chopper.sv
module incr_burst_chopper #(
  parameter int CFG_W     = 3,
  parameter int MAX_BEATS = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       htrans_i,
  input  logic [2:0]       hburst_i,
  input  logic             hready_i,
  input  logic [CFG_W-1:0] ulen_code_i,
  output logic             vend_o
);

  localparam int CNT_W = $clog2(MAX_BEATS);

  logic             rst_n_s;
  logic             start, done, drop, active;
  logic             code_en;
  logic [CNT_W-1:0] code_term;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term_q;

  ulb_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  ulb_len_decode #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_dec (
    .code_i (ulen_code_i),
    .en_o   (code_en),
    .term_o (code_term)
  );

  ulb_xfer_class u_cls (
    .htrans_i (htrans_i),
    .hburst_i (hburst_i),
    .hready_i (hready_i),
    .active_i (active),
    .start_o  (start),
    .done_o   (done),
    .drop_o   (drop)
  );

  ulb_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (start),
    .done_i      (done),
    .drop_i      (drop),
    .code_en_i   (code_en),
    .code_term_i (code_term),
    .hit_o       (vend_o),
    .active_o    (active),
    .cnt_o       (cnt_q),
    .term_o      (term_q)
  );

endmodule

// File: rtl/ulb_chk.sv
module ulb_chk #(
  parameter int CFG_W = 3,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       htrans_i,
  input logic [2:0]       hburst_i,
  input logic             hready_i,
  input logic [CFG_W-1:0] ulen_code_i,
  input logic             vend_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] term_q
);

  p_pulse_on_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vend_o |-> (hready_i && htrans_i[1] && hburst_i == 3'b001));

  p_unlimited_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_i == 2'b10 && ulen_code_i == '0) |-> !vend_o);

  p_single_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_i == 2'b10 && hburst_i == 3'b001 && hready_i && ulen_code_i == CFG_W'(1))
      |-> vend_o);

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term_q);

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vend_o |=> (cnt_q == '0));

  p_busy_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_i == 2'b01) |-> (!vend_o ##1 $stable(cnt_q)));

  p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready_i && htrans_i == 2'b11) |-> !vend_o);

  p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_i == 2'b00) |=> (cnt_q == '0));

endmodule

bind incr_burst_chopper ulb_chk #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .htrans_i    (htrans_i),
  .hburst_i    (hburst_i),
  .hready_i    (hready_i),
  .ulen_code_i (ulen_code_i),
  .vend_o      (vend_o),
  .cnt_q       (cnt_q),
  .term_q      (term_q)
);

// File: tb/incr_burst_chopper_tb_top.sv
`timescale 1ns/100ps
module incr_burst_chopper_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] htrans;
  logic [2:0] hburst;
  logic       hready;
  logic [2:0] code;
  logic       vend;

  always #2.5 clk = ~clk;

  incr_burst_chopper dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .htrans_i    (htrans),
    .hburst_i    (hburst),
    .hready_i    (hready),
    .ulen_code_i (code),
    .vend_o      (vend)
  );

  int    n_total = 0;
  int    n_fail  = 0;
  string tag     = "R11";
  int    m_cnt   = 0;
  int    m_len   = 0;
  bit    m_act   = 0;
  int    pulses  = 0;

  function automatic int len_of(input int c);
    if (c == 0) return 0;
    if (c == 1) return 1;
    return 1 << c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One bus cycle: drive, compare against the model at the negedge, advance model.
  task automatic cyc(input logic [1:0] tr, input logic [2:0] hb,
                     input logic rdy, input logic [2:0] cf);
    bit incr, st, cn, dn, ex;
    int n, c;
    htrans = tr; hburst = hb; hready = rdy; code = cf;
    @(negedge clk);
    incr = (hb == 3'b001);
    st   = incr && (tr == 2'b10);
    cn   = incr && (tr == 2'b11) && m_act;
    dn   = (st || cn) && rdy;
    n    = st ? len_of(int'(cf)) : m_len;
    c    = st ? 0 : m_cnt;
    ex   = dn && (n != 0) && (c == n - 1);
    check(vend == ex, tag, "per-cycle pulse", int'(vend), int'(ex));
    if (vend) pulses++;
    if (!incr || tr == 2'b00) begin
      m_cnt = 0; m_act = 0;
    end else if (st) begin
      m_act = 1; m_len = n;
      m_cnt = (dn && !ex && n != 0) ? 1 : 0;
    end else if (dn) begin
      m_cnt = ex ? 0 : c + 1;
    end
    @(posedge clk);
    #0.5;
  endtask

  // A burst of len beats; optional BUSY every busy_gap beats, a wait state
  // before every wait_gap-th beat, code switched to cf1 after the first beat.
  task automatic burst(input int cf0, input int cf1, input int len,
                       input logic [2:0] hb, input int busy_gap, input int wait_gap,
                       input bit end_idle, input string req);
    int exp_p;
    int n;
    tag    = req;
    pulses = 0;
    for (int i = 0; i < len; i++) begin
      logic [1:0] tr;
      logic [2:0] cf;
      tr = (i == 0) ? 2'b10 : 2'b11;
      cf = (i == 0) ? 3'(cf0) : 3'(cf1);
      if (wait_gap != 0 && (i % wait_gap) == wait_gap - 1) cyc(tr, hb, 1'b0, cf);
      cyc(tr, hb, 1'b1, cf);
      if (busy_gap != 0 && (i % busy_gap) == busy_gap - 1 && i < len - 1)
        cyc(2'b01, hb, 1'b1, 3'(cf1));
    end
    if (end_idle) cyc(2'b00, hb, 1'b1, 3'(cf1));
    n     = len_of(cf0);
    exp_p = (hb == 3'b001 && n != 0) ? len / n : 0;
    check(pulses == exp_p, req, "pulse count over burst", pulses, exp_p);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    n_total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    htrans = 2'b10; hburst = 3'b001; hready = 1'b1; code = 3'd1;
    // R11: pulse stays low while reset is held, even with a single-beat setup.
    repeat (3) begin
      @(negedge clk);
      check(vend == 1'b0, "R11", "pulse during reset", int'(vend), 0);
    end
    htrans = 2'b00;
    @(posedge clk); #0.5;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #0.5;
    // R11: after reset no burst is tracked; stray SEQ beats give nothing.
    tag = "R11";
    pulses = 0;
    for (int i = 0; i < 6; i++) cyc(2'b11, 3'b001, 1'b1, 3'd1);
    check(pulses == 0, "R11", "no tracking after reset", pulses, 0);

    burst(0, 0, 140, 3'b001, 0, 0, 1, "R2");
    burst(1, 1, 9,   3'b001, 0, 0, 1, "R3");
    for (int c = 2; c < 8; c++) begin
      burst(c, c, (1 << c) * 2 + 3, 3'b001, 0, 0, 1, "R4");
    end
    burst(2, 2, 37, 3'b001, 0, 0, 1, "R4");
    burst(3, 3, 13, 3'b001, 0, 0, 1, "R4");
    burst(7, 7, 256, 3'b001, 0, 0, 1, "R4");
    burst(2, 2, 23, 3'b001, 2, 0, 1, "R6");
    burst(3, 3, 30, 3'b001, 1, 0, 1, "R6");
    burst(2, 2, 19, 3'b001, 0, 3, 1, "R7");
    burst(1, 1, 6,  3'b001, 2, 2, 1, "R7");
    // R5: back-to-back bursts without IDLE; count must restart.
    burst(2, 2, 3, 3'b001, 0, 0, 0, "R5");
    burst(2, 2, 6, 3'b001, 0, 0, 1, "R5");
    burst(3, 3, 7, 3'b001, 0, 0, 0, "R5");
    burst(3, 3, 9, 3'b001, 0, 0, 1, "R5");
    // R8: IDLE ends tracking, following SEQ beats give nothing.
    burst(2, 2, 3, 3'b001, 0, 0, 1, "R8");
    pulses = 0;
    for (int i = 0; i < 9; i++) cyc(2'b11, 3'b001, 1'b1, 3'd2);
    check(pulses == 0, "R8", "SEQ after IDLE", pulses, 0);
    cyc(2'b00, 3'b001, 1'b1, 3'd2);
    // R9: other burst types never produce a pulse.
    burst(1, 1, 8,  3'b011, 0, 0, 1, "R9");
    burst(2, 2, 16, 3'b111, 0, 0, 1, "R9");
    burst(1, 1, 1,  3'b000, 0, 0, 1, "R9");
    // R10: code change mid-burst has no effect until the next NONSEQ.
    burst(2, 1, 11, 3'b001, 0, 0, 1, "R10");
    burst(0, 1, 10, 3'b001, 0, 0, 1, "R10");
    burst(1, 0, 5,  3'b001, 0, 0, 1, "R10");
    // R1: completing beats only; a mix of everything.
    burst(3, 3, 21, 3'b001, 3, 4, 1, "R1");

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule